// File: doc/BRIEF.md
# Flat Panel Output Signal Conditioner

This block sits between a display timing generator and a flat panel interface. Every pixel clock it takes the horizontal and vertical blank flags, a raw line-pulse strobe and a 36-bit pixel word. From these it produces the panel display-enable, a gated line pulse and a packed panel data bus. All three outputs are registered, with the same one-cycle latency, so they stay aligned.

A byte-wide control register sets how the outputs behave. It selects the panel data width and decides whether data is forced to all ones during vertical blank. It also sets whether line pulses run through vertical blank and whether display-enable follows horizontal blank alone or both blanks. Software reaches the register through an index/data port pair: it first writes an index to the index port, then reads or writes the data port.

The pixel word carries three 12-bit channels: red in bits 35:24, green in 23:12 and blue in 11:0. Narrow modes keep the most significant bits of each channel and pack them from bit 0 upward.

Top module: `fp_sig_cond`

## Requirements
- R1: After reset, de_out, lp_out and data_out are 0, and the control register reads 0x00.
- R2: The control register is selected when the index port holds 0x12. A data-port write with that index stores bits 7:3, and bits 2:0 always read as 0. A data-port write under any other index leaves the register unchanged. dat_rdata returns the stored byte while the index is 0x12 and returns 0 otherwise.
- R3: Width code 00 in bits 7:6 selects 16-bit 5-6-5 output. data_out[15:11] = red[11:7], data_out[10:5] = green[11:6], data_out[4:0] = blue[11:7], and bits 35:16 are 0.
- R4: Width code 01 selects 24-bit 8-8-8 output. data_out[23:16] = red[11:4], data_out[15:8] = green[11:4], data_out[7:0] = blue[11:4], and bits 35:24 are 0.
- R5: Width code 11 selects 36-bit output, and data_out equals pix_in.
- R6: Width code 10 is reserved and drives data_out to 0, even when the force bit is set.
- R7: When bit 5 is set and vblank is high, every bit inside the selected width is 1 and the bits above it stay 0. Bit 5 has no effect while vblank is low, and data passes unchanged when bit 5 is clear.
- R8: When bit 3 is 0, de_out = NOT(hblank OR vblank).
- R9: When bit 3 is 1, de_out = NOT hblank, so display-enable stays active during vertical blank.
- R10: lp_out follows lp_in, except that it is held low during vblank unless bit 4 or bit 3 is set. With both bits clear, a frame of 240 active lines and 20 blank lines yields exactly 240 output line pulses.
- R11: Each output reflects the inputs and the control value present at the preceding clock edge: one cycle of latency on every path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Index value to store |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Data port write value |
| dat_rdata | output | 8 | Data port read value |
| hblank | input | 1 | Horizontal blank flag |
| vblank | input | 1 | Vertical blank flag |
| lp_in | input | 1 | Raw line-pulse strobe |
| pix_in | input | 36 | Pixel word, three 12-bit channels R:G:B |
| de_out | output | 1 | Panel display-enable |
| lp_out | output | 1 | Gated line pulse |
| data_out | output | 36 | Packed panel data |

## Verification
The bench drives the reserved width code with the force bit set. A design that let forcing override the reserved code would show ones where zeros belong. It writes under a wrong index and then reads back, which catches any decoder that ignores the index. It runs a whole 260-line frame and counts output line pulses, so gating that leaks in vertical blank gives more than 240. It checks that forced-high data fills only the selected width, and it samples the outputs just before and just after the edge, so a path with the wrong latency shows up as a stale or early value.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int CH_W  = 12;
    localparam int PIX_W = 3 * CH_W;
    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        FPW_16  = 2'b00,
        FPW_24  = 2'b01,
        FPW_RSV = 2'b10,
        FPW_36  = 2'b11
    } fp_width_e;

    // Packed so that the struct maps onto register bits 7:3.
    typedef struct packed {
        fp_width_e width;
        logic      force_hi;
        logic      force_lp;
        logic      de_hb_only;
    } fp_ctrl_t;

    localparam int CTRL_W = $bits(fp_ctrl_t);
    localparam int PAD_W  = REG_W - CTRL_W;

    function automatic logic [PIX_W-1:0] width_mask(fp_width_e w);
        logic [PIX_W-1:0] m;
        case (w)
            FPW_16:  m = {{(PIX_W-16){1'b0}}, {16{1'b1}}};
            FPW_24:  m = {{(PIX_W-24){1'b0}}, {24{1'b1}}};
            FPW_36:  m = {PIX_W{1'b1}};
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [PIX_W-1:0] pack_pixel(fp_width_e w, logic [PIX_W-1:0] p);
        logic [CH_W-1:0]  r, g, b;
        logic [PIX_W-1:0] o;
        r = p[3*CH_W-1 -: CH_W];
        g = p[2*CH_W-1 -: CH_W];
        b = p[CH_W-1   -: CH_W];
        o = '0;
        case (w)
            FPW_16:  o[15:0] = {r[CH_W-1 -: 5], g[CH_W-1 -: 6], b[CH_W-1 -: 5]};
            FPW_24:  o[23:0] = {r[CH_W-1 -: 8], g[CH_W-1 -: 8], b[CH_W-1 -: 8]};
            FPW_36:  o = p;
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/fpc_ctrl_reg.sv
module fpc_ctrl_reg
    import fpc_pkg::*;
#(
    parameter int                  IDX_W      = 8,
    parameter logic [IDX_W-1:0]    CTRL_INDEX = 8'h12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             dat_we,
    input  logic [REG_W-1:0] dat_wdata,
    output fp_ctrl_t         ctrl,
    output logic [REG_W-1:0] rdata
);

    logic [IDX_W-1:0] index_q;
    fp_ctrl_t         ctrl_q;
    logic             hit;

    assign hit = (index_q == CTRL_INDEX);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
        end else if (idx_we) begin
            index_q <= idx_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (dat_we && hit) begin
            ctrl_q <= fp_ctrl_t'(dat_wdata[REG_W-1 -: CTRL_W]);
        end
    end

    assign ctrl  = ctrl_q;
    assign rdata = hit ? {ctrl_q, {PAD_W{1'b0}}} : '0;

endmodule

// File: rtl/fpc_gate.sv
module fpc_gate
    import fpc_pkg::*;
(
    input  fp_ctrl_t ctrl,
    input  logic     hblank,
    input  logic     vblank,
    input  logic     lp_in,
    output logic     de_nxt,
    output logic     lp_nxt
);

    logic lp_pass_vb;

    always_comb begin
        if (ctrl.de_hb_only) begin
            de_nxt = ~hblank;
        end else begin
            de_nxt = ~(hblank | vblank);
        end
        lp_pass_vb = ctrl.force_lp | ctrl.de_hb_only;
        lp_nxt     = lp_in & (~vblank | lp_pass_vb);
    end

endmodule

// File: rtl/fpc_pack.sv
module fpc_pack
    import fpc_pkg::*;
(
    input  fp_ctrl_t         ctrl,
    input  logic             vblank,
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W-1:0] data_nxt
);

    logic [PIX_W-1:0] packed_pix;
    logic [PIX_W-1:0] mask;

    always_comb begin
        packed_pix = pack_pixel(ctrl.width, pix);
        mask       = width_mask(ctrl.width);
        if (ctrl.force_hi && vblank) begin
            data_nxt = mask;
        end else begin
            data_nxt = packed_pix;
        end
    end

endmodule

// File: rtl/fp_sig_cond.sv
module fp_sig_cond
    import fpc_pkg::*;
#(
    parameter int               IDX_W      = 8,
    parameter logic [IDX_W-1:0] CTRL_INDEX = 8'h12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    output logic [7:0]       dat_rdata,
    input  logic             hblank,
    input  logic             vblank,
    input  logic             lp_in,
    input  logic [35:0]      pix_in,
    output logic             de_out,
    output logic             lp_out,
    output logic [35:0]      data_out
);

    fp_ctrl_t         ctrl_q;
    logic             de_nxt, lp_nxt;
    logic [PIX_W-1:0] data_nxt;

    typedef struct packed {
        logic             de;
        logic             lp;
        logic [PIX_W-1:0] data;
    } fp_out_t;

    fp_out_t out_q;

    fpc_ctrl_reg #(
        .IDX_W      (IDX_W),
        .CTRL_INDEX (CTRL_INDEX)
    ) u_reg (
        .clk       (clk),
        .rst       (rst),
        .idx_we    (idx_we),
        .idx_wdata (idx_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .ctrl      (ctrl_q),
        .rdata     (dat_rdata)
    );

    fpc_gate u_gate (
        .ctrl   (ctrl_q),
        .hblank (hblank),
        .vblank (vblank),
        .lp_in  (lp_in),
        .de_nxt (de_nxt),
        .lp_nxt (lp_nxt)
    );

    fpc_pack u_pack (
        .ctrl     (ctrl_q),
        .vblank   (vblank),
        .pix      (pix_in),
        .data_nxt (data_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= '{de: de_nxt, lp: lp_nxt, data: data_nxt};
        end
    end

    assign de_out   = out_q.de;
    assign lp_out   = out_q.lp;
    assign data_out = out_q.data;

endmodule

// File: rtl/fpc_chk.sv
module fpc_chk
    import fpc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hblank,
    input logic             vblank,
    input logic             lp_in,
    input fp_ctrl_t         ctrl,
    input logic             de_out,
    input logic             lp_out,
    input logic [PIX_W-1:0] data_out
);

    logic live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R8
    de_off_in_vblank_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(vblank) && !$past(ctrl.de_hb_only) |-> !de_out);

    // R9
    de_off_in_hblank_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(hblank) |-> !de_out);

    // R10
    lp_suppressed_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(vblank) && !$past(ctrl.force_lp) && !$past(ctrl.de_hb_only)
        |-> !lp_out);

    // R10
    lp_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && lp_out |-> $past(lp_in));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && ($past(ctrl.width) == FPW_RSV) |-> (data_out == '0));

    // R3
    upper_low_16_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && ($past(ctrl.width) == FPW_16) |-> (data_out[PIX_W-1:16] == '0));

    // R7
    force_high_24_chk: assert property (@(posedge clk) disable iff (rst)
        live_q && ($past(ctrl.width) == FPW_24) && $past(ctrl.force_hi) && $past(vblank)
        |-> (data_out == {{(PIX_W-24){1'b0}}, {24{1'b1}}}));

endmodule

bind fp_sig_cond fpc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .hblank   (hblank),
    .vblank   (vblank),
    .lp_in    (lp_in),
    .ctrl     (ctrl_q),
    .de_out   (de_out),
    .lp_out   (lp_out),
    .data_out (data_out)
);

// File: tb/tb_fp_sig_cond.sv
`timescale 1ns/1ps
module tb_fp_sig_cond;

    logic        clk = 1'b0;
    logic        rst;
    logic        idx_we, dat_we;
    logic [7:0]  idx_wdata, dat_wdata, dat_rdata;
    logic        hblank, vblank, lp_in;
    logic [35:0] pix_in, data_out;
    logic        de_out, lp_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    fp_sig_cond dut (
        .clk(clk), .rst(rst),
        .idx_we(idx_we), .idx_wdata(idx_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .hblank(hblank), .vblank(vblank), .lp_in(lp_in), .pix_in(pix_in),
        .de_out(de_out), .lp_out(lp_out), .data_out(data_out)
    );

    task automatic check(string req, logic [35:0] got, logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] idx, logic [7:0] val);
        @(negedge clk); idx_we = 1'b1; idx_wdata = idx;
        @(negedge clk); idx_we = 1'b0; dat_we = 1'b1; dat_wdata = val;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic set_idx(logic [7:0] idx);
        @(negedge clk); idx_we = 1'b1; idx_wdata = idx;
        @(negedge clk); idx_we = 1'b0;
    endtask

    // Drive inputs after a falling edge, then sample just after the rising edge.
    task automatic step(logic hb, logic vb, logic lp, logic [35:0] px);
        @(negedge clk);
        hblank = hb; vblank = vb; lp_in = lp; pix_in = px;
        @(posedge clk); #1;
    endtask

    function automatic logic [35:0] exp16(logic [35:0] p);
        return {20'b0, p[35:31], p[23:18], p[11:7]};
    endfunction
    function automatic logic [35:0] exp24(logic [35:0] p);
        return {12'b0, p[35:28], p[23:16], p[11:4]};
    endfunction

    task automatic t_reset();
        check("R1 de", {35'b0, de_out}, 36'h0);
        check("R1 lp", {35'b0, lp_out}, 36'h0);
        check("R1 data", data_out, 36'h0);
        set_idx(8'h12);
        check("R1 reg", {28'b0, dat_rdata}, 36'h0);
    endtask

    task automatic t_regs();
        wr_reg(8'h12, 8'hFF);
        check("R2 readback", {28'b0, dat_rdata}, 36'hF8);
        wr_reg(8'h13, 8'h00);
        check("R2 other index reads 0", {28'b0, dat_rdata}, 36'h0);
        set_idx(8'h12);
        check("R2 unchanged", {28'b0, dat_rdata}, 36'hF8);
        wr_reg(8'h12, 8'h48);
        check("R2 rewrite", {28'b0, dat_rdata}, 36'h48);
    endtask

    task automatic t_pack();
        logic [35:0] px [3] = '{36'hFFF_000_ABC, 36'h123_456_789, 36'h800_7FF_F0F};
        wr_reg(8'h12, 8'h00);
        foreach (px[i]) begin
            step(0, 0, 0, px[i]);
            check("R3 16-bit pack", data_out, exp16(px[i]));
        end
        wr_reg(8'h12, 8'h40);
        foreach (px[i]) begin
            step(0, 0, 0, px[i]);
            check("R4 24-bit pack", data_out, exp24(px[i]));
        end
        wr_reg(8'h12, 8'hC0);
        foreach (px[i]) begin
            step(0, 0, 0, px[i]);
            check("R5 36-bit pass", data_out, px[i]);
        end
        // R11: output holds until the next rising edge, then updates
        @(negedge clk); pix_in = 36'hA5A_5A5_A5A; #1;
        check("R11 before edge", data_out, px[2]);
        @(posedge clk); #1;
        check("R11 after edge", data_out, 36'hA5A_5A5_A5A);
        wr_reg(8'h12, 8'hA0);
        step(0, 1, 0, 36'hFFF_FFF_FFF);
        check("R6 reserved forced", data_out, 36'h0);
        step(0, 0, 0, 36'h123_456_789);
        check("R6 reserved", data_out, 36'h0);
    endtask

    task automatic t_force();
        wr_reg(8'h12, 8'h60);
        step(0, 1, 0, 36'h0);
        check("R7 24-bit forced", data_out, 36'h000_FFF_FFF);
        step(0, 0, 0, 36'h123_456_789);
        check("R7 no vblank", data_out, exp24(36'h123_456_789));
        wr_reg(8'h12, 8'h20);
        step(0, 1, 0, 36'h0);
        check("R7 16-bit forced", data_out, 36'h000_00F_FFF & 36'h0_0000_FFFF);
        wr_reg(8'h12, 8'hE0);
        step(0, 1, 0, 36'h0);
        check("R7 36-bit forced", data_out, 36'hFFF_FFF_FFF);
        wr_reg(8'h12, 8'h40);
        step(0, 1, 0, 36'h123_456_789);
        check("R7 force clear", data_out, exp24(36'h123_456_789));
    endtask

    task automatic t_de();
        wr_reg(8'h12, 8'h00);
        step(0, 0, 0, 0); check("R8 active", {35'b0, de_out}, 36'h1);
        step(1, 0, 0, 0); check("R8 hblank", {35'b0, de_out}, 36'h0);
        step(0, 1, 0, 0); check("R8 vblank", {35'b0, de_out}, 36'h0);
        wr_reg(8'h12, 8'h08);
        step(0, 1, 0, 0); check("R9 vblank", {35'b0, de_out}, 36'h1);
        step(1, 1, 0, 0); check("R9 hblank", {35'b0, de_out}, 36'h0);
        step(1, 0, 0, 0); check("R9 hblank only", {35'b0, de_out}, 36'h0);
    endtask

    task automatic run_frame(output int pulses);
        pulses = 0;
        for (int ln = 0; ln < 260; ln++) begin
            for (int c = 0; c < 4; c++) begin
                step(c != 0, ln >= 240, c == 0, 0);
                if (lp_out) pulses++;
            end
        end
    endtask

    task automatic t_lp();
        int cnt;
        wr_reg(8'h12, 8'h00);
        step(1, 0, 1, 0); check("R10 pass active", {35'b0, lp_out}, 36'h1);
        step(1, 1, 1, 0); check("R10 gated vblank", {35'b0, lp_out}, 36'h0);
        run_frame(cnt);
        check("R10 240 pulses", 36'(cnt), 36'd240);
        wr_reg(8'h12, 8'h10);
        step(1, 1, 1, 0); check("R10 force lp", {35'b0, lp_out}, 36'h1);
        run_frame(cnt);
        check("R10 260 pulses", 36'(cnt), 36'd260);
        wr_reg(8'h12, 8'h08);
        step(1, 1, 1, 0); check("R10 de select", {35'b0, lp_out}, 36'h1);
    endtask

    initial begin
        rst = 1'b1; idx_we = 0; dat_we = 0; idx_wdata = 0; dat_wdata = 0;
        hblank = 0; vblank = 0; lp_in = 0; pix_in = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_regs();
        t_pack();
        t_force();
        t_de();
        t_lp();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule